// File: doc/BRIEF.md
# Debug Mode Hart Mailbox Memory

This block is a small memory region that a debug controller serves to halted harts. A hart in Debug Mode fetches its parking code from a constant ROM inside the region. It tells the controller that it has stopped by storing its own hart ID to a mailbox word. It then polls a byte of its own in a flag area. The controller raises a go request or a resume request for each hart separately. The hart acknowledges a request by storing its ID to one of two acknowledge words, and that store clears the request. A store to a separate exception word tells the command logic, through a one-cycle pulse, that something in the command sequence trapped.

The region also holds the program-buffer and data words. The data words start at byte offset 0x400, so a single load or store based on x0 with a 12-bit immediate reaches them. The program-buffer words sit directly below 0x400, so buffer and data form one contiguous run. The controller reads and writes these words through its own port.

Only a hart in Debug Mode sees the region. For any other hart, reads return zero and writes change nothing.

Top module: `dbg_mailbox`

## Requirements
- R1: A Debug Mode store of value h (0 <= h < NUM_HARTS) to byte 0x100 sets halted_o[h] from the next cycle on.
- R2: A pulse on go_i[h] sets bit 0 and a pulse on resume_i[h] sets bit 1 of hart h's flag byte. Flag byte h is byte (h mod 4) of the word at 0x300 + 4*(h div 4), and its other bits read 0.
- R3: A Debug Mode store of h to 0x104 clears the go bit of hart h. If a go_i[h] pulse arrives in the same cycle, the bit stays set.
- R4: A Debug Mode store of h to 0x108 clears the resume bit of hart h and also clears halted_o[h].
- R5: A Debug Mode store to 0x10C drives exception_o high for exactly the next cycle. exception_o is low in every other cycle.
- R6: Data word k sits at byte 0x400 + 4*k. A hart store writes only the bytes whose bit in hart_strb_i is 1 (bit i covers bits 8i+7..8i). The controller port (ctl_prog_i = 0) reads and writes the same word.
- R7: Program-buffer word j sits at 0x400 - 4*PROG_WORDS + 4*j, so the last buffer word is directly followed by data word 0. The controller reaches it with ctl_prog_i = 1.
- R8: When hart_dbg_mode_i is 0, hart reads return 0. Hart writes then change no halted bit, flag bit, buffer word or data word, and raise no exception pulse.
- R9: The ROM sits at 0x800 and holds nop, fence, dret and ebreak. Word 0x808 reads 0x7b200073, which is the dret entry.
- R10: If the hart and the controller write the same data word in the same cycle, the hart's bytes win.
- R11: Stores of an ID of NUM_HARTS or more to the halt or acknowledge words change no state.
- R12: hart_rdata_o updates in the cycle after a read request and holds otherwise. Unmapped addresses and the halt, acknowledge and exception words read 0.
- R13: After reset, halted_o, every flag, every buffer and data word, exception_o and hart_rdata_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hart_req_i | input | 1 | Hart access valid |
| hart_we_i | input | 1 | Access is a store |
| hart_addr_i | input | 10 | Word address (byte address bits 11..2) |
| hart_wdata_i | input | 32 | Store data |
| hart_strb_i | input | 4 | Byte strobes for buffer and data stores |
| hart_dbg_mode_i | input | 1 | Accessing hart is in Debug Mode |
| hart_rdata_o | output | 32 | Registered read data |
| go_i | input | NUM_HARTS | Per-hart go request pulse |
| resume_i | input | NUM_HARTS | Per-hart resume request pulse |
| halted_o | output | NUM_HARTS | Per-hart halted status |
| exception_o | output | 1 | One-cycle exception pulse |
| ctl_we_i | input | 1 | Controller word write |
| ctl_prog_i | input | 1 | 1 selects the program buffer, 0 selects data |
| ctl_idx_i | input | CTL_IDX_W | Word index within the selected bank |
| ctl_wdata_i | input | 32 | Controller write data |
| ctl_rdata_o | output | 32 | Selected word, combinational; 0 when out of range |

## Verification
The bench sweeps every go and resume mask over four harts. It checks that each flag bit lands in the correct byte lane of the flag word. A lane or shift mistake would show up as a bit in another hart's byte. It fires set and acknowledge in the same cycle, where the wrong priority would drop a fresh request. It sends IDs at and above the hart count, which a design that truncates the ID would alias onto a real hart. It runs all sixteen strobe patterns on each data word and writes the same word from both sides in one cycle. A wrong byte mask or the wrong winner then leaves a mixed word. It also reads across the boundary between buffer and data words and repeats the stores with Debug Mode off, where a leak would change a bit or read back data.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WA_W   = ADDR_W - 2;

  localparam logic [ADDR_W-1:0] HALT_ADDR     = 12'h100;
  localparam logic [ADDR_W-1:0] GOING_ADDR    = 12'h104;
  localparam logic [ADDR_W-1:0] RESUMING_ADDR = 12'h108;
  localparam logic [ADDR_W-1:0] EXC_ADDR      = 12'h10C;
  localparam logic [ADDR_W-1:0] FLAG_BASE     = 12'h300;
  localparam logic [ADDR_W-1:0] DATA_BASE     = 12'h400;
  localparam logic [ADDR_W-1:0] ROM_BASE      = 12'h800;
  localparam logic [ADDR_W-1:0] RESUME_ENTRY  = 12'h808;
  localparam int unsigned       ROM_WORDS     = 4;

  localparam logic [31:0] NOP_INSN    = 32'h0000_0013;
  localparam logic [31:0] FENCE_INSN  = 32'h0ff0_000f;
  localparam logic [31:0] DRET_INSN   = 32'h7b20_0073;
  localparam logic [31:0] EBREAK_INSN = 32'h0010_0073;

  typedef enum logic [2:0] {
    REG_NONE, REG_HALT, REG_GOING, REG_RESUMING,
    REG_EXC, REG_FLAG, REG_RAM, REG_ROM
  } region_e;

  typedef struct packed {
    region_e         region;
    logic [WA_W-1:0] idx;   // word offset inside the region
  } decode_t;

  function automatic logic [31:0] rom_word(input logic [WA_W-1:0] i);
    case (i)
      WA_W'(0): rom_word = NOP_INSN;
      WA_W'(1): rom_word = FENCE_INSN;
      WA_W'(2): rom_word = DRET_INSN;
      WA_W'(3): rom_word = EBREAK_INSN;
      default:  rom_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_mailbox_decode.sv
module dbg_mailbox_decode
  import dbg_mailbox_pkg::*;
#(
  parameter int unsigned NUM_HARTS  = 4,
  parameter int unsigned DATA_WORDS = 2,
  parameter int unsigned PROG_WORDS = 4
) (
  input  logic [WA_W-1:0] wa_i,
  output decode_t         dec_o
);
  localparam int unsigned FLAG_WORDS = (NUM_HARTS + 3) / 4;
  localparam logic [WA_W-1:0] HALT_WA  = HALT_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] GOING_WA = GOING_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] RES_WA   = RESUMING_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] EXC_WA   = EXC_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] FLAG_LO  = FLAG_BASE[ADDR_W-1:2];
  localparam logic [WA_W-1:0] FLAG_HI  = FLAG_LO + WA_W'(FLAG_WORDS);
  localparam logic [WA_W-1:0] RAM_LO   = DATA_BASE[ADDR_W-1:2] - WA_W'(PROG_WORDS);
  localparam logic [WA_W-1:0] RAM_HI   = DATA_BASE[ADDR_W-1:2] + WA_W'(DATA_WORDS);
  localparam logic [WA_W-1:0] ROM_LO   = ROM_BASE[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ROM_HI   = ROM_LO + WA_W'(ROM_WORDS);

  always_comb begin
    dec_o.region = REG_NONE;
    dec_o.idx    = '0;
    if (wa_i == HALT_WA) begin
      dec_o.region = REG_HALT;
    end else if (wa_i == GOING_WA) begin
      dec_o.region = REG_GOING;
    end else if (wa_i == RES_WA) begin
      dec_o.region = REG_RESUMING;
    end else if (wa_i == EXC_WA) begin
      dec_o.region = REG_EXC;
    end else if (wa_i >= FLAG_LO && wa_i < FLAG_HI) begin
      dec_o.region = REG_FLAG;
      dec_o.idx    = wa_i - FLAG_LO;
    end else if (wa_i >= RAM_LO && wa_i < RAM_HI) begin
      dec_o.region = REG_RAM;
      dec_o.idx    = wa_i - RAM_LO;
    end else if (wa_i >= ROM_LO && wa_i < ROM_HI) begin
      dec_o.region = REG_ROM;
      dec_o.idx    = wa_i - ROM_LO;
    end
  end
endmodule

// File: rtl/dbg_mailbox_flags.sv
module dbg_mailbox_flags #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_HARTS-1:0] go_req_i,
  input  logic [NUM_HARTS-1:0] resume_req_i,
  input  logic                 halt_we_i,
  input  logic                 going_we_i,
  input  logic                 resuming_we_i,
  input  logic [31:0]          id_i,
  output logic [NUM_HARTS-1:0] go_o,
  output logic [NUM_HARTS-1:0] resume_o,
  output logic [NUM_HARTS-1:0] halted_o
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic hit;
    logic go_q, res_q, halt_q;
    // full-width compare: out-of-range IDs match no hart
    assign hit = (id_i == 32'(h));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        go_q   <= 1'b0;
        res_q  <= 1'b0;
        halt_q <= 1'b0;
      end else begin
        if (go_req_i[h])               go_q <= 1'b1;
        else if (going_we_i && hit)    go_q <= 1'b0;
        if (resume_req_i[h])           res_q <= 1'b1;
        else if (resuming_we_i && hit) res_q <= 1'b0;
        if (halt_we_i && hit)          halt_q <= 1'b1;
        else if (resuming_we_i && hit) halt_q <= 1'b0;
      end
    end

    assign go_o[h]     = go_q;
    assign resume_o[h] = res_q;
    assign halted_o[h] = halt_q;
  end
endmodule

// File: rtl/dbg_mailbox_ram.sv
module dbg_mailbox_ram #(
  parameter int unsigned WORDS = 6,
  parameter int unsigned IDX_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hart_we_i,
  input  logic [IDX_W-1:0]      hart_idx_i,
  input  logic [3:0]            hart_strb_i,
  input  logic [31:0]           hart_wdata_i,
  input  logic                  ctl_we_i,
  input  logic [IDX_W-1:0]      ctl_idx_i,
  input  logic [31:0]           ctl_wdata_i,
  output logic [WORDS-1:0][31:0] mem_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] q;
    logic        hart_hit, ctl_hit;
    assign hart_hit = hart_we_i && (hart_idx_i == IDX_W'(w));
    assign ctl_hit  = ctl_we_i && (ctl_idx_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hart_hit) begin
        // hart side has priority over the controller
        for (int b = 0; b < 4; b++) begin
          if (hart_strb_i[b]) q[8*b +: 8] <= hart_wdata_i[8*b +: 8];
        end
      end else if (ctl_hit) begin
        q <= ctl_wdata_i;
      end
    end
    assign mem_o[w] = q;
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int unsigned NUM_HARTS  = 4,
  parameter int unsigned DATA_WORDS = 2,
  parameter int unsigned PROG_WORDS = 4,
  localparam int unsigned MAX_WORDS = (DATA_WORDS > PROG_WORDS) ? DATA_WORDS : PROG_WORDS,
  localparam int unsigned CTL_IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hart_req_i,
  input  logic                 hart_we_i,
  input  logic [WA_W-1:0]      hart_addr_i,
  input  logic [31:0]          hart_wdata_i,
  input  logic [3:0]           hart_strb_i,
  input  logic                 hart_dbg_mode_i,
  output logic [31:0]          hart_rdata_o,
  input  logic [NUM_HARTS-1:0] go_i,
  input  logic [NUM_HARTS-1:0] resume_i,
  output logic [NUM_HARTS-1:0] halted_o,
  output logic                 exception_o,
  input  logic                 ctl_we_i,
  input  logic                 ctl_prog_i,
  input  logic [CTL_IDX_W-1:0] ctl_idx_i,
  input  logic [31:0]          ctl_wdata_i,
  output logic [31:0]          ctl_rdata_o
);
  localparam int unsigned RAM_WORDS = PROG_WORDS + DATA_WORDS;

  decode_t dec;
  logic    hart_wr, hart_rd;
  logic    ctl_in_range;
  logic [WA_W-1:0] ctl_ram_idx;
  logic [NUM_HARTS-1:0] go_q, res_q;
  logic [RAM_WORDS-1:0][31:0] ram_q;
  logic [31:0] rd_d, rdata_q;
  logic        exc_q;

  assign hart_wr = hart_req_i && hart_we_i && hart_dbg_mode_i;
  assign hart_rd = hart_req_i && !hart_we_i;

  dbg_mailbox_decode #(
    .NUM_HARTS (NUM_HARTS),
    .DATA_WORDS(DATA_WORDS),
    .PROG_WORDS(PROG_WORDS)
  ) u_decode (
    .wa_i (hart_addr_i),
    .dec_o(dec)
  );

  dbg_mailbox_flags #(
    .NUM_HARTS(NUM_HARTS)
  ) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_req_i     (go_i),
    .resume_req_i (resume_i),
    .halt_we_i    (hart_wr && dec.region == REG_HALT),
    .going_we_i   (hart_wr && dec.region == REG_GOING),
    .resuming_we_i(hart_wr && dec.region == REG_RESUMING),
    .id_i         (hart_wdata_i),
    .go_o         (go_q),
    .resume_o     (res_q),
    .halted_o     (halted_o)
  );

  // controller index: buffer words first, data words after them
  always_comb begin
    if (ctl_prog_i) begin
      ctl_in_range = 32'(ctl_idx_i) < PROG_WORDS;
      ctl_ram_idx  = WA_W'(ctl_idx_i);
    end else begin
      ctl_in_range = 32'(ctl_idx_i) < DATA_WORDS;
      ctl_ram_idx  = WA_W'(PROG_WORDS) + WA_W'(ctl_idx_i);
    end
  end

  dbg_mailbox_ram #(
    .WORDS(RAM_WORDS),
    .IDX_W(WA_W)
  ) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hart_we_i   (hart_wr && dec.region == REG_RAM),
    .hart_idx_i  (dec.idx),
    .hart_strb_i (hart_strb_i),
    .hart_wdata_i(hart_wdata_i),
    .ctl_we_i    (ctl_we_i && ctl_in_range),
    .ctl_idx_i   (ctl_ram_idx),
    .ctl_wdata_i (ctl_wdata_i),
    .mem_o       (ram_q)
  );

  always_comb begin
    ctl_rdata_o = '0;
    for (int w = 0; w < RAM_WORDS; w++) begin
      if (ctl_in_range && ctl_ram_idx == WA_W'(w)) ctl_rdata_o = ram_q[w];
    end
  end

  // hart read mux
  always_comb begin
    rd_d = '0;
    case (dec.region)
      REG_FLAG: begin
        for (int h = 0; h < NUM_HARTS; h++) begin
          if (32'(h / 4) == 32'(dec.idx))
            rd_d[(h % 4)*8 +: 8] = {6'b0, res_q[h], go_q[h]};
        end
      end
      REG_RAM: begin
        for (int w = 0; w < RAM_WORDS; w++) begin
          if (dec.idx == WA_W'(w)) rd_d = ram_q[w];
        end
      end
      REG_ROM: rd_d = rom_word(dec.idx);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      if (hart_rd) rdata_q <= hart_dbg_mode_i ? rd_d : 32'h0;
      exc_q <= hart_wr && dec.region == REG_EXC;
    end
  end

  assign hart_rdata_o = rdata_q;
  assign exception_o  = exc_q;
endmodule

// File: rtl/dbg_mailbox_sva.sv
module dbg_mailbox_sva
  import dbg_mailbox_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hart_req_i,
  input logic                 hart_we_i,
  input logic [WA_W-1:0]      hart_addr_i,
  input logic [31:0]          hart_wdata_i,
  input logic                 hart_dbg_mode_i,
  input logic [31:0]          hart_rdata_o,
  input logic [NUM_HARTS-1:0] halted_o,
  input logic                 exception_o
);
  logic wr, exc_wr, dret_rd;
  assign wr      = hart_req_i && hart_we_i && hart_dbg_mode_i;
  assign exc_wr  = wr && hart_addr_i == EXC_ADDR[ADDR_W-1:2];
  assign dret_rd = hart_req_i && !hart_we_i && hart_dbg_mode_i &&
                   hart_addr_i == RESUME_ENTRY[ADDR_W-1:2];

  assert_exc_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_wr |=> exception_o);
  assert_exc_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_wr |=> !exception_o);
  assert_halted_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(halted_o));
  assert_rd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_req_i && !hart_we_i && !hart_dbg_mode_i) |=> hart_rdata_o == 32'h0);
  assert_rom_dret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dret_rd |=> hart_rdata_o == DRET_INSN);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assert_halt_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hart_addr_i == HALT_ADDR[ADDR_W-1:2] && hart_wdata_i == 32'(h))
      |=> halted_o[h]);
    assert_resume_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && hart_addr_i == RESUMING_ADDR[ADDR_W-1:2] && hart_wdata_i == 32'(h))
      |=> !halted_o[h]);
  end
endmodule

bind dbg_mailbox dbg_mailbox_sva #(
  .NUM_HARTS(NUM_HARTS)
) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .hart_req_i     (hart_req_i),
  .hart_we_i      (hart_we_i),
  .hart_addr_i    (hart_addr_i),
  .hart_wdata_i   (hart_wdata_i),
  .hart_dbg_mode_i(hart_dbg_mode_i),
  .hart_rdata_o   (hart_rdata_o),
  .halted_o       (halted_o),
  .exception_o    (exception_o)
);

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;
  localparam int NH = 4;
  localparam int ND = 2;
  localparam int NP = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hart_req_i = 1'b0, hart_we_i = 1'b0, hart_dbg_mode_i = 1'b0;
  logic [9:0]  hart_addr_i = '0;
  logic [31:0] hart_wdata_i = '0;
  logic [3:0]  hart_strb_i = '0;
  logic [31:0] hart_rdata_o;
  logic [NH-1:0] go_i = '0, resume_i = '0, halted_o;
  logic        exception_o;
  logic        ctl_we_i = 1'b0, ctl_prog_i = 1'b0;
  logic [1:0]  ctl_idx_i = '0;
  logic [31:0] ctl_wdata_i = '0, ctl_rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NH-1:0] e_halt = '0, e_go = '0, e_res = '0;

  always #10 clk_i = ~clk_i;

  dbg_mailbox #(.NUM_HARTS(NH), .DATA_WORDS(ND), .PROG_WORDS(NP)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] s, input logic dbg);
    @(negedge clk_i);
    hart_req_i = 1; hart_we_i = 1; hart_addr_i = a[11:2];
    hart_wdata_i = d; hart_strb_i = s; hart_dbg_mode_i = dbg;
    @(negedge clk_i);
    hart_req_i = 0; hart_we_i = 0;
  endtask

  task automatic hrd(input logic [11:0] a, input logic dbg, output logic [31:0] d);
    @(negedge clk_i);
    hart_req_i = 1; hart_we_i = 0; hart_addr_i = a[11:2]; hart_dbg_mode_i = dbg;
    @(negedge clk_i);
    hart_req_i = 0;
    d = hart_rdata_o;
  endtask

  task automatic cwr(input logic prog, input logic [1:0] k, input logic [31:0] d);
    @(negedge clk_i);
    ctl_we_i = 1; ctl_prog_i = prog; ctl_idx_i = k; ctl_wdata_i = d;
    @(negedge clk_i);
    ctl_we_i = 0;
  endtask

  task automatic crd(input logic prog, input logic [1:0] k, output logic [31:0] d);
    ctl_prog_i = prog; ctl_idx_i = k;
    #1 d = ctl_rdata_o;
  endtask

  task automatic pulse(input logic [NH-1:0] g, input logic [NH-1:0] r);
    @(negedge clk_i);
    go_i = g; resume_i = r;
    @(negedge clk_i);
    go_i = '0; resume_i = '0;
  endtask

  function automatic logic [31:0] flag_word();
    logic [31:0] w = '0;
    for (int h = 0; h < NH; h++) w[8*h +: 8] = {6'b0, e_res[h], e_go[h]};
    return w;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R13 reset state
    chk("R13 halted", 32'(halted_o), 0);
    chk("R13 exception", 32'(exception_o), 0);
    chk("R13 rdata", hart_rdata_o, 0);
    for (int k = 0; k < ND; k++) begin crd(0, 2'(k), rd); chk("R13 data", rd, 0); end
    for (int j = 0; j < NP; j++) begin crd(1, 2'(j), rd); chk("R13 prog", rd, 0); end
    hrd(12'h300, 1, rd); chk("R13 flags", rd, 0);

    // R9 ROM
    hrd(12'h800, 1, rd); chk("R9 rom0", rd, 32'h0000_0013);
    hrd(12'h804, 1, rd); chk("R9 rom1", rd, 32'h0ff0_000f);
    hrd(12'h808, 1, rd); chk("R9 dret", rd, 32'h7b20_0073);
    hrd(12'h80C, 1, rd); chk("R9 rom3", rd, 32'h0010_0073);

    // R12 unmapped and mailbox words read zero, rdata holds
    hrd(12'h000, 1, rd); chk("R12 unmapped", rd, 0);
    hrd(12'h808, 1, rd);
    repeat (2) @(negedge clk_i);
    chk("R12 hold", hart_rdata_o, 32'h7b20_0073);
    hrd(12'h104, 1, rd); chk("R12 ack reads 0", rd, 0);
    hrd(12'hFFC, 1, rd); chk("R12 top", rd, 0);

    // R1 halt sweep
    for (int h = 0; h < NH; h++) begin
      hwr(12'h100, 32'(h), 4'hF, 1);
      e_halt[h] = 1;
      chk("R1 halted", 32'(halted_o), 32'(e_halt));
    end

    // R11 out-of-range IDs
    hwr(12'h108, 32'd4, 4'hF, 1); chk("R11 res id4", 32'(halted_o), 32'(e_halt));
    hwr(12'h108, 32'h8000_0001, 4'hF, 1); chk("R11 res hi", 32'(halted_o), 32'(e_halt));
    pulse(4'hF, 4'h0); e_go = 4'hF;
    hwr(12'h104, 32'd5, 4'hF, 1);
    hrd(12'h300, 1, rd); chk("R11 go ack id5", rd, flag_word());
    for (int h = 0; h < NH; h++) hwr(12'h104, 32'(h), 4'hF, 1);
    e_go = '0;

    // R2/R3 go sweep
    for (int p = 0; p < 16; p++) begin
      pulse(4'(p), 4'h0); e_go = 4'(p);
      hrd(12'h300, 1, rd); chk("R2 go flags", rd, flag_word());
      for (int h = 0; h < NH; h++) begin
        if (p[h]) begin
          hwr(12'h104, 32'(h), 4'hF, 1); e_go[h] = 0;
          hrd(12'h300, 1, rd); chk("R3 go ack", rd, flag_word());
        end
      end
    end

    // R3 set wins over same-cycle ack
    @(negedge clk_i);
    go_i = 4'b0100; hart_req_i = 1; hart_we_i = 1; hart_dbg_mode_i = 1;
    hart_addr_i = 12'h104 >> 2; hart_wdata_i = 32'd2;
    @(negedge clk_i);
    go_i = '0; hart_req_i = 0; hart_we_i = 0; e_go[2] = 1;
    hrd(12'h300, 1, rd); chk("R3 set wins", rd, flag_word());
    hwr(12'h104, 32'd2, 4'hF, 1); e_go[2] = 0;

    // R2/R4 resume sweep
    for (int p = 0; p < 16; p++) begin
      for (int h = 0; h < NH; h++) hwr(12'h100, 32'(h), 4'hF, 1);
      e_halt = 4'hF;
      pulse(4'h0, 4'(p)); e_res = 4'(p);
      hrd(12'h300, 1, rd); chk("R2 res flags", rd, flag_word());
      for (int h = 0; h < NH; h++) begin
        if (p[h]) begin
          hwr(12'h108, 32'(h), 4'hF, 1); e_res[h] = 0; e_halt[h] = 0;
          chk("R4 halted clr", 32'(halted_o), 32'(e_halt));
        end
      end
      hrd(12'h300, 1, rd); chk("R4 res flags", rd, flag_word());
    end

    // R5 exception pulse
    hwr(12'h10C, 32'h0, 4'hF, 1);
    chk("R5 pulse high", 32'(exception_o), 1);
    @(negedge clk_i); chk("R5 pulse low", 32'(exception_o), 0);

    // R6 data strobe sweep
    for (int k = 0; k < ND; k++) begin
      for (int s = 0; s < 16; s++) begin
        ev = 32'h1122_3344 ^ (32'(k) << 28);
        cwr(0, 2'(k), ev);
        hwr(12'(12'h400 + 4*k), 32'hA0B0_C0D0 + 32'(s), 4'(s), 1);
        ev = merge(ev, 32'hA0B0_C0D0 + 32'(s), 4'(s));
        hrd(12'(12'h400 + 4*k), 1, rd); chk("R6 hart rd", rd, ev);
        crd(0, 2'(k), rd); chk("R6 ctl rd", rd, ev);
      end
    end

    // R7 program buffer placement
    for (int j = 0; j < NP; j++) begin
      cwr(1, 2'(j), 32'hC0DE_0000 + 32'(j));
      hrd(12'(12'h3F0 + 4*j), 1, rd); chk("R7 prog hart rd", rd, 32'hC0DE_0000 + 32'(j));
      hwr(12'(12'h3F0 + 4*j), 32'h5A00_0000 + 32'(j), 4'hF, 1);
      crd(1, 2'(j), rd); chk("R7 prog ctl rd", rd, 32'h5A00_0000 + 32'(j));
    end
    cwr(0, 0, 32'hDA7A_0000);
    hrd(12'h3FC, 1, rd); chk("R7 last prog", rd, 32'h5A00_0003);
    hrd(12'h400, 1, rd); chk("R7 first data", rd, 32'hDA7A_0000);

    // R8 outside Debug Mode
    hrd(12'h400, 0, rd); chk("R8 rd zero", rd, 0);
    hrd(12'h808, 0, rd); chk("R8 rom zero", rd, 0);
    hwr(12'h400, 32'hFFFF_FFFF, 4'hF, 0);
    crd(0, 0, rd); chk("R8 data kept", rd, 32'hDA7A_0000);
    hwr(12'h3F0, 32'hFFFF_FFFF, 4'hF, 0);
    crd(1, 0, rd); chk("R8 prog kept", rd, 32'h5A00_0000);
    hwr(12'h100, 32'd1, 4'hF, 0);
    chk("R8 halt kept", 32'(halted_o), 32'(e_halt));
    hwr(12'h10C, 32'd0, 4'hF, 0);
    chk("R8 no exc", 32'(exception_o), 0);
    pulse(4'b0010, 4'h0); e_go[1] = 1;
    hwr(12'h104, 32'd1, 4'hF, 0);
    hrd(12'h300, 1, rd); chk("R8 go kept", rd, flag_word());
    hwr(12'h104, 32'd1, 4'hF, 1); e_go[1] = 0;

    // R10 same-cycle conflict
    @(negedge clk_i);
    ctl_we_i = 1; ctl_prog_i = 0; ctl_idx_i = 1; ctl_wdata_i = 32'h1111_1111;
    hart_req_i = 1; hart_we_i = 1; hart_dbg_mode_i = 1; hart_addr_i = 12'h404 >> 2;
    hart_wdata_i = 32'h2222_2222; hart_strb_i = 4'hF;
    @(negedge clk_i);
    ctl_we_i = 0; hart_req_i = 0; hart_we_i = 0;
    crd(0, 1, rd); chk("R10 hart wins", rd, 32'h2222_2222);
    @(negedge clk_i);
    ctl_we_i = 1; ctl_prog_i = 0; ctl_idx_i = 0; ctl_wdata_i = 32'h3333_3333;
    hart_req_i = 1; hart_we_i = 1; hart_addr_i = 12'h404 >> 2; hart_wdata_i = 32'h4444_4444;
    @(negedge clk_i);
    ctl_we_i = 0; hart_req_i = 0; hart_we_i = 0;
    crd(0, 0, rd); chk("R10 other word ctl", rd, 32'h3333_3333);
    crd(0, 1, rd); chk("R10 other word hart", rd, 32'h4444_4444);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule